// File: doc/BRIEF.md
# Power Cut Timer Controller

This block watches two supply comparators while the system is running. When the main supply drops below the undervoltage level, it declares a power cut. It then keeps every supply except the backup domain switched off, and it times how long the system may ride out the dropout on the backup cell. The allowed duration comes from a programmed value. Each cut loads that value into a private down-counter, so the programmed value stays intact for every later cut.

A cut ends in one of two ways, and each ends with a one-cycle request to the mode controller. If the supply recovers in the proper order before the time runs out, the block requests a Cold Start. Proper order means the supply must first pass the undervoltage level and then the power-on level. If the counter runs out first, the block requests Off. In that case it also clears a status bit that software can later set again by writing a one.

Top module: `pcut_guard`

## Requirements
- R1: After reset the block is idle: `cut_active_o`, `req_off_o` and `req_cold_o` are 0, and `survive_ok_o` is 1. Asserting `arst_n` low forces this state at once, even in the middle of a cut.
- R2: When the block is idle, `act_mode_i` is 1 and `sup_uv_ok_i` is 0 at a clock edge, `cut_active_o` goes to 1 after that edge. When `act_mode_i` is 0, no cut starts.
- R3: Entering a cut loads the down-counter from `dur_cfg_i`. The counter changes only on cycles where `tick_i` is 1. For a duration D of 1 or more, the cut expires on the D-th tick. For D = 0, it expires on the first tick. Changes to `dur_cfg_i` during a cut have no effect.
- R4: On expiry, `req_off_o` is 1 for exactly one cycle, `cut_active_o` returns to 0 in that same cycle, and `survive_ok_o` becomes 0.
- R5: During a cut, recovery happens when `sup_uv_ok_i` was already 1 in the previous cycle and both comparators are 1 now. A 1 on `sup_pon_ok_i` without a prior rise of `sup_uv_ok_i` never counts. Recovery gives a one-cycle `req_cold_o` pulse and ends the cut.
- R6: During a cut, a fall of `sup_uv_ok_i` back to 0 clears the ordering progress. Such a new drop does not reload the counter.
- R7: If recovery and expiry fall in the same cycle, recovery wins: `req_cold_o` pulses, `req_off_o` stays 0 and `survive_ok_o` is unchanged.
- R8: A 1 on `exp_w1s_i` sets `survive_ok_o` to 1 after the edge. When an expiry happens in the same cycle, the expiry wins and the bit becomes 0. Otherwise the bit holds its value.
- R9: `req_off_o` and `req_cold_o` are never 1 together. Each is 1 for only one cycle at a time, and only in the cycle right after a cut ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| act_mode_i | input | 1 | 1 while the system is in an active mode; enables cut detection |
| sup_uv_ok_i | input | 1 | 1 when the main supply is above the undervoltage threshold |
| sup_pon_ok_i | input | 1 | 1 when the main supply is above the power-on threshold |
| dur_cfg_i | input | CNT_W | Programmed maximum cut duration in ticks |
| tick_i | input | 1 | Slow tick enable for the cut timer |
| exp_w1s_i | input | 1 | Software write-one that sets the status bit |
| cut_active_o | output | 1 | 1 during a cut; all non-backup supplies are off |
| req_off_o | output | 1 | One-cycle request for Off after an unsuccessful cut |
| req_cold_o | output | 1 | One-cycle request for Cold Start after a successful cut |
| survive_ok_o | output | 1 | Status: 0 after a cut expired, 1 after reset or a software set |

## Verification
The bench builds the block with its defaults: an 8-bit counter and a two-stage reset synchronizer. It keeps the programmed durations small (0, 2, 3), so every expiry lands within a few ticks. At that scale the table can reach several corner cases: expiry on a zero duration, a counter that a repeated drop must not reload, and recovery and expiry falling in the same cycle. Because ticks can be withheld row by row, the table also shows that time passes only on enabled cycles. It also shows that a duration change during a cut is ignored.

// File: rtl/pcut_pkg.sv
package pcut_pkg;

  typedef enum logic {
    PC_IDLE = 1'b0,
    PC_CUT  = 1'b1
  } pc_state_e;

endpackage

// File: rtl/pcut_rst_sync.sv
module pcut_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/pcut_dncnt.sv
module pcut_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Zero or one left: the next enabled tick ends the window.
  assign last_o = (cnt_q <= ONE);

endmodule

// File: rtl/pcut_order_trk.sv
module pcut_order_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic track_i,
  input  logic uv_i,
  input  logic pon_i,
  output logic recover_o
);

  logic seen_q;
  logic seen_d;

  // Remembers an undervoltage rise seen during the cut; a fall clears it.
  always_comb begin
    seen_d = track_i & uv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

  assign recover_o = track_i & seen_q & uv_i & pon_i;

endmodule

// File: rtl/pcut_guard.sv
module pcut_guard
  import pcut_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             act_mode_i,
  input  logic             sup_uv_ok_i,
  input  logic             sup_pon_ok_i,
  input  logic [CNT_W-1:0] dur_cfg_i,
  input  logic             tick_i,
  input  logic             exp_w1s_i,
  output logic             cut_active_o,
  output logic             req_off_o,
  output logic             req_cold_o,
  output logic             survive_ok_o
);

  logic      rst_n;
  pc_state_e state_q, state_d;
  logic      off_q, off_d;
  logic      cold_q, cold_d;
  logic      ok_q, ok_d;
  logic      in_cut;
  logic      start;
  logic      last;
  logic      expire;
  logic      recover;

  pcut_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pcut_dncnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start),
    .load_val_i (dur_cfg_i),
    .dec_i      (in_cut & tick_i),
    .last_o     (last)
  );

  pcut_order_trk u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .track_i   (in_cut),
    .uv_i      (sup_uv_ok_i),
    .pon_i     (sup_pon_ok_i),
    .recover_o (recover)
  );

  assign in_cut = (state_q == PC_CUT);
  assign start  = !in_cut && act_mode_i && !sup_uv_ok_i;
  assign expire = in_cut && tick_i && last;

  always_comb begin
    state_d = state_q;
    off_d   = 1'b0;
    cold_d  = 1'b0;
    unique case (state_q)
      PC_IDLE: begin
        if (start) state_d = PC_CUT;
      end
      PC_CUT: begin
        if (recover) begin
          state_d = PC_IDLE;
          cold_d  = 1'b1;
        end else if (expire) begin
          state_d = PC_IDLE;
          off_d   = 1'b1;
        end
      end
      default: state_d = PC_IDLE;
    endcase
    if (off_d) begin
      ok_d = 1'b0;
    end else if (exp_w1s_i) begin
      ok_d = 1'b1;
    end else begin
      ok_d = ok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PC_IDLE;
      off_q   <= 1'b0;
      cold_q  <= 1'b0;
      ok_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      cold_q  <= cold_d;
      ok_q    <= ok_d;
    end
  end

  assign cut_active_o = in_cut;
  assign req_off_o    = off_q;
  assign req_cold_o   = cold_q;
  assign survive_ok_o = ok_q;

endmodule

// File: rtl/pcut_guard_chk.sv
module pcut_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             arst_n,
  input logic             act_mode_i,
  input logic             sup_uv_ok_i,
  input logic             sup_pon_ok_i,
  input logic [CNT_W-1:0] dur_cfg_i,
  input logic             tick_i,
  input logic             exp_w1s_i,
  input logic             cut_active_o,
  input logic             req_off_o,
  input logic             req_cold_o,
  input logic             survive_ok_o
);

  a_r9_excl: assert property (@(posedge clk) disable iff (!arst_n)
    !(req_off_o && req_cold_o));

  a_r9_off_single: assert property (@(posedge clk) disable iff (!arst_n)
    req_off_o |=> !req_off_o);

  a_r9_cold_single: assert property (@(posedge clk) disable iff (!arst_n)
    req_cold_o |=> !req_cold_o);

  a_r4_off_ends_cut: assert property (@(posedge clk) disable iff (!arst_n)
    req_off_o |-> (!cut_active_o && $past(cut_active_o)));

  a_r4_off_clears: assert property (@(posedge clk) disable iff (!arst_n)
    req_off_o |-> !survive_ok_o);

  a_r5_cold_order: assert property (@(posedge clk) disable iff (!arst_n)
    req_cold_o |-> ($past(cut_active_o) && $past(sup_uv_ok_i) && $past(sup_pon_ok_i)));

  a_r2_no_cut_inactive: assert property (@(posedge clk) disable iff (!arst_n)
    (!cut_active_o && !act_mode_i) |=> !cut_active_o);

  a_r8_w1s_sets: assert property (@(posedge clk) disable iff (!arst_n)
    exp_w1s_i |=> (survive_ok_o || req_off_o));

endmodule

bind pcut_guard pcut_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .arst_n       (arst_n),
  .act_mode_i   (act_mode_i),
  .sup_uv_ok_i  (sup_uv_ok_i),
  .sup_pon_ok_i (sup_pon_ok_i),
  .dur_cfg_i    (dur_cfg_i),
  .tick_i       (tick_i),
  .exp_w1s_i    (exp_w1s_i),
  .cut_active_o (cut_active_o),
  .req_off_o    (req_off_o),
  .req_cold_o   (req_cold_o),
  .survive_ok_o (survive_ok_o)
);

// File: tb/sim_pcut_guard.sv
module sim_pcut_guard;

  localparam int CNT_W = 8;
  localparam int NV    = 30;

  logic             clk;
  logic             arst_n;
  logic             act_mode_i;
  logic             sup_uv_ok_i;
  logic             sup_pon_ok_i;
  logic [CNT_W-1:0] dur_cfg_i;
  logic             tick_i;
  logic             exp_w1s_i;
  logic             cut_active_o;
  logic             req_off_o;
  logic             req_cold_o;
  logic             survive_ok_o;

  int checks;
  int errors;
  bit done;

  pcut_guard #(.CNT_W(CNT_W)) u0 (
    .clk          (clk),
    .arst_n       (arst_n),
    .act_mode_i   (act_mode_i),
    .sup_uv_ok_i  (sup_uv_ok_i),
    .sup_pon_ok_i (sup_pon_ok_i),
    .dur_cfg_i    (dur_cfg_i),
    .tick_i       (tick_i),
    .exp_w1s_i    (exp_w1s_i),
    .cut_active_o (cut_active_o),
    .req_off_o    (req_off_o),
    .req_cold_o   (req_cold_o),
    .survive_ok_o (survive_ok_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Row: {req tag, dur, act uv pon tick w1s, exp cut off cold ok}
  localparam logic [20:0] VECS [0:NV-1] = '{
    {4'd2, 8'd2, 5'b11100, 4'b0001},  // R2 supply fine: stay idle
    {4'd2, 8'd2, 5'b10000, 4'b1001},  // R2 drop starts cut, load 2
    {4'd3, 8'd2, 5'b10010, 4'b1001},  // R3 tick: 2 -> 1
    {4'd5, 8'd2, 5'b10100, 4'b1001},  // R5 power-on alone: no recovery
    {4'd5, 8'd2, 5'b11000, 4'b1001},  // R5 undervoltage rises
    {4'd5, 8'd2, 5'b11100, 4'b0011},  // R5 ordered recovery: cold start
    {4'd9, 8'd2, 5'b11100, 4'b0001},  // R9 pulse gone
    {4'd2, 8'd2, 5'b10000, 4'b1001},  // R2 new cut, load 2
    {4'd3, 8'd2, 5'b10010, 4'b1001},  // R3 tick: 2 -> 1
    {4'd3, 8'd9, 5'b10000, 4'b1001},  // R3 no tick, duration change ignored
    {4'd4, 8'd9, 5'b10010, 4'b0100},  // R4 second tick: expiry
    {4'd2, 8'd2, 5'b00000, 4'b0000},  // R2 inactive: no cut
    {4'd8, 8'd2, 5'b01101, 4'b0001},  // R8 write-one sets status
    {4'd2, 8'd3, 5'b10000, 4'b1001},  // R2 cut, load 3
    {4'd6, 8'd3, 5'b11000, 4'b1001},  // R6 undervoltage rises
    {4'd6, 8'd3, 5'b10010, 4'b1001},  // R6 falls again, tick: 3 -> 2
    {4'd5, 8'd3, 5'b10100, 4'b1001},  // R5 power-on without order
    {4'd5, 8'd3, 5'b11110, 4'b1001},  // R5 both high same cycle: not yet; 2 -> 1
    {4'd7, 8'd3, 5'b11110, 4'b0011},  // R7 recovery beats expiry
    {4'd2, 8'd2, 5'b10000, 4'b1001},  // R2 cut, load 2
    {4'd3, 8'd2, 5'b10010, 4'b1001},  // R3 tick: 2 -> 1
    {4'd6, 8'd2, 5'b11000, 4'b1001},  // R6 rise
    {4'd6, 8'd2, 5'b10000, 4'b1001},  // R6 repeated drop, no reload
    {4'd6, 8'd2, 5'b10010, 4'b0100},  // R6 expires on second tick overall
    {4'd8, 8'd2, 5'b11100, 4'b0000},  // R8 status holds at 0
    {4'd8, 8'd0, 5'b10001, 4'b1001},  // R8 set while entering zero-length cut
    {4'd3, 8'd0, 5'b10010, 4'b0100},  // R3 zero duration: first tick expires
    {4'd8, 8'd0, 5'b10001, 4'b1001},  // R8 set again, cut entered
    {4'd8, 8'd0, 5'b10011, 4'b0100},  // R8 expiry wins over write-one
    {4'd9, 8'd0, 5'b01100, 4'b0000}   // R9 pulses cleared
  };

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [3:0] e);
    chk(tag, "cut_active_o", cut_active_o, e[3]);
    chk(tag, "req_off_o",    req_off_o,    e[2]);
    chk(tag, "req_cold_o",   req_cold_o,   e[1]);
    chk(tag, "survive_ok_o", survive_ok_o, e[0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got running expected finished");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    arst_n = 1'b0;
    act_mode_i = 1'b0;
    sup_uv_ok_i = 1'b1;
    sup_pon_ok_i = 1'b1;
    dur_cfg_i = '0;
    tick_i = 1'b0;
    exp_w1s_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1", 4'b0001);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1", 4'b0001);

    for (int i = 0; i < NV; i++) begin
      dur_cfg_i    = VECS[i][16:9];
      act_mode_i   = VECS[i][8];
      sup_uv_ok_i  = VECS[i][7];
      sup_pon_ok_i = VECS[i][6];
      tick_i       = VECS[i][5];
      exp_w1s_i    = VECS[i][4];
      @(negedge clk);
      chk_all($sformatf("R%0d row%0d", VECS[i][20:17], i), VECS[i][3:0]);
    end

    // R1: asynchronous reset in the middle of a cut
    dur_cfg_i = 8'd5;
    act_mode_i = 1'b1;
    sup_uv_ok_i = 1'b0;
    sup_pon_ok_i = 1'b0;
    tick_i = 1'b0;
    exp_w1s_i = 1'b0;
    @(negedge clk);
    chk("R2", "cut_active_o", cut_active_o, 1'b1);
    #5 arst_n = 1'b0;
    #1;
    chk_all("R1", 4'b0001);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", "cut_active_o", cut_active_o, 1'b1);

    // R3: tick only the full 5-count expires
    tick_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", "cut_active_o", cut_active_o, 1'b1);
    @(negedge clk);
    chk_all("R3", 4'b0100);

    finish_run();
  end

endmodule